// File: doc/BRIEF.md
# Serial Comma Detector and Word Aligner

This block sits behind a clock-and-data-recovery stage and receives one recovered bit per bit clock. It assembles the bits into 10-bit words on a word boundary that it maintains itself. While the alignment enable is high, it looks in a sliding window for the positive-disparity comma prefix. If that prefix is found straddling the current boundary, the block moves the boundary so that the next word starts with the bit that follows the comma. After that, every comma that is sent a whole number of words later comes out with its first bit on word bit 0.

Each word is presented with a one-cycle valid strobe and is then held until the next word. A sync flag travels with every word that starts with a comma. When the boundary moves, the block gives a one-cycle realign request together with the accumulated boundary offset, so that a byte-clock generator can follow. The word that the move cuts short is dropped rather than sent early. This way the word period is only ever stretched.

Top module: `comma_aligner`

## Requirements
- R1: A comma is a window whose seven earliest bits, in arrival order, are 0,0,1,1,1,1,1. The last three bits of the window are don't-care. On the word port, with bit 0 received first, this is word[6:0] == 7'b1111100.
- R2: Bits fill the word in arrival order: the first bit of a word appears on word[0] and the tenth on word[9].
- R3: When the last bit of a comma lands on the current boundary, the word holding it is delivered with syncFlag high, and no realign request is made.
- R4: When syncEn is high and the last bit of a comma lands anywhere other than the current boundary, realignReq pulses for one cycle and the partial word is discarded (wordValid stays low in that cycle). The next word starts with the bit after the comma.
- R5: realignOffset holds the sum, modulo 10, of the bit shifts made by all realignments since reset. The shift of one realignment is the number of bits of the discarded partial word. The offset is always below 10.
- R6: While syncEn is low, no realign request is made, realignOffset and the boundary stay unchanged, and syncFlag is never set.
- R7: wordValid is a one-cycle pulse, raised in the cycle after the clock edge that samples the word's tenth bit. Pulses are exactly 10 cycles apart, except that a realignment stretches the gap to 10 plus the shift.
- R8: word and syncFlag hold their values between valid pulses.
- R9: After reset, word is 0, wordValid, syncFlag and realignReq are low, and realignOffset is 0.
- R10: After one realignment, a comma that arrives a whole number of words after the first is delivered aligned on word[0] with syncFlag high. The data words between the two commas come out intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| serIn | input | 1 | Recovered serial data bit |
| syncEn | input | 1 | Enables comma search and boundary moves |
| word | output | 10 | Last completed word, bit 0 received first |
| wordValid | output | 1 | One-cycle strobe when a new word is presented |
| syncFlag | output | 1 | High with a word that begins with a comma |
| realignReq | output | 1 | One-cycle pulse when the boundary moves |
| realignOffset | output | 4 | Accumulated boundary offset, modulo 10 |

## Verification
The bench sends a comma preceded by every class of misalignment: none, one bit, a middle value, and nine bits (the largest shift). It then checks that the data after the comma, and a second comma 40 bits later, come out intact and in bit order. A design that emitted the cut-short word, or that restarted the boundary one bit off, would show up here as a short gap between valid pulses or as rotated data words. A chain of realignments whose shifts sum past 10 exercises the modulo wrap of the offset, which a plain adder would get wrong. A comma sent with the enable low must leave the offset, the boundary and the sync flag untouched. The bench also checks that the flag stays high for the whole period of the comma word.

// File: rtl/ca_pkg.sv
package ca_pkg;

  // Strobes handed from the alignment control to the datapath each bit clock.
  typedef struct packed {
    logic emit;      // present the window as a completed word this edge
    logic restart;   // start a new word with the next bit (boundary moves)
    logic commaHit;  // the word being presented begins with a comma
  } alignCmd_t;

endpackage

// File: rtl/ca_datapath.sv
module ca_datapath
  import ca_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int PHASE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  alignCmd_t         cmd,
  output logic [WORD_W-1:0] winNext,
  output logic [PHASE_W-1:0] phase,
  output logic [WORD_W-1:0] word,
  output logic              wordValid,
  output logic              syncFlag
);

  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(WORD_W - 1);

  logic [WORD_W-1:0] win;

  // Newest bit enters at the top, so the oldest bit ends at position 0.
  assign winNext = {serIn, win[WORD_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      win <= '0;
    end else begin
      win <= winNext;
    end
  end

  // Count of bits already taken into the current word.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
    end else if (cmd.restart || (phase == LAST_PHASE)) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      word      <= '0;
      wordValid <= 1'b0;
      syncFlag  <= 1'b0;
    end else begin
      wordValid <= cmd.emit;
      if (cmd.emit) begin
        word     <= winNext;
        syncFlag <= cmd.commaHit;
      end
    end
  end

endmodule

// File: rtl/ca_control.sv
module ca_control
  import ca_pkg::*;
#(
  parameter int                 WORD_W    = 10,
  parameter int                 PHASE_W   = 4,
  parameter int                 COMMA_W   = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               syncEn,
  input  logic [COMMA_W-1:0] commaWin,
  input  logic [PHASE_W-1:0] phase,
  output alignCmd_t          cmd,
  output logic               realignReq,
  output logic [PHASE_W-1:0] realignOffset
);

  localparam int SUM_W = PHASE_W + 1;
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(WORD_W - 1);
  localparam logic [SUM_W-1:0]   WORD_SUM   = SUM_W'(WORD_W);

  logic [COMMA_W-1:0] bitHit;
  logic               match;
  logic               atBoundary;
  logic [SUM_W-1:0]   sumRaw;
  logic [SUM_W-1:0]   sumWrap;

  for (genvar i = 0; i < COMMA_W; i++) begin : g_cmp
    assign bitHit[i] = (commaWin[i] == COMMA_PAT[i]);
  end

  assign match      = syncEn && (&bitHit);
  assign atBoundary = (phase == LAST_PHASE);

  always_comb begin
    cmd.emit     = atBoundary;
    cmd.commaHit = match && atBoundary;
    cmd.restart  = match && !atBoundary;
  end

  // New offset = old offset + bits of the dropped partial word, modulo the word size.
  assign sumRaw  = {1'b0, realignOffset} + {1'b0, phase} + SUM_W'(1);
  assign sumWrap = (sumRaw >= WORD_SUM) ? (sumRaw - WORD_SUM) : sumRaw;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      realignReq    <= 1'b0;
      realignOffset <= '0;
    end else begin
      realignReq <= cmd.restart;
      if (cmd.restart) begin
        realignOffset <= sumWrap[PHASE_W-1:0];
      end
    end
  end

endmodule

// File: rtl/comma_aligner.sv
module comma_aligner
  import ca_pkg::*;
#(
  parameter int                 WORD_W    = 10,
  parameter int                 COMMA_W   = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100,
  localparam int                PHASE_W   = $clog2(WORD_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serIn,
  input  logic               syncEn,
  output logic [WORD_W-1:0]  word,
  output logic               wordValid,
  output logic               syncFlag,
  output logic               realignReq,
  output logic [PHASE_W-1:0] realignOffset
);

  alignCmd_t          cmd;
  logic [WORD_W-1:0]  winNext;
  logic [PHASE_W-1:0] phase;

  ca_datapath #(
    .WORD_W (WORD_W),
    .PHASE_W(PHASE_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .serIn    (serIn),
    .cmd      (cmd),
    .winNext  (winNext),
    .phase    (phase),
    .word     (word),
    .wordValid(wordValid),
    .syncFlag (syncFlag)
  );

  ca_control #(
    .WORD_W   (WORD_W),
    .PHASE_W  (PHASE_W),
    .COMMA_W  (COMMA_W),
    .COMMA_PAT(COMMA_PAT)
  ) u_control (
    .clk          (clk),
    .rstN         (rstN),
    .syncEn       (syncEn),
    .commaWin     (winNext[COMMA_W-1:0]),
    .phase        (phase),
    .cmd          (cmd),
    .realignReq   (realignReq),
    .realignOffset(realignOffset)
  );

endmodule

// File: rtl/comma_aligner_chk.sv
module comma_aligner_chk #(
  parameter int                 WORD_W    = 10,
  parameter int                 COMMA_W   = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100,
  parameter int                 PHASE_W   = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               syncEn,
  input logic [WORD_W-1:0]  word,
  input logic               wordValid,
  input logic               syncFlag,
  input logic               realignReq,
  input logic [PHASE_W-1:0] realignOffset
);

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  assert_realign_drops_word_R4: assert property (@(posedge clk) disable iff (!rstN)
    realignReq |-> !wordValid);

  assert_flag_comma_R1: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && syncFlag) |-> (word[COMMA_W-1:0] == COMMA_PAT));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> ($stable(word) && $stable(syncFlag)));

  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(syncEn) |-> (!realignReq && $stable(realignOffset)));

  assert_offset_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    int'(realignOffset) < WORD_W);

endmodule

bind comma_aligner comma_aligner_chk #(
  .WORD_W   (WORD_W),
  .COMMA_W  (COMMA_W),
  .COMMA_PAT(COMMA_PAT),
  .PHASE_W  (PHASE_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .syncEn       (syncEn),
  .word         (word),
  .wordValid    (wordValid),
  .syncFlag     (syncFlag),
  .realignReq   (realignReq),
  .realignOffset(realignOffset)
);

// File: tb/comma_aligner_bench.sv
module comma_aligner_bench;

  localparam int CLK_PERIOD = 10;

  // Words as driven, bit 0 sent first.
  localparam logic [9:0] COMMA = 10'h17C;  // 0,0,1,1,1,1,1,0,1,0 in arrival order
  localparam logic [9:0] D1 = 10'h155;
  localparam logic [9:0] D2 = 10'h2AA;
  localparam logic [9:0] D3 = 10'h0F0;
  localparam logic [9:0] D4 = 10'h333;

  // Vector fields: [9] enable, [8:5] lead-in zero bits, [4] realign expected, [3:0] expected offset
  localparam int NVEC = 6;
  localparam logic [9:0] VEC [NVEC] = '{
    10'b1_0000_0_0000,
    10'b1_0011_1_0011,
    10'b1_1001_1_1001,
    10'b1_0001_1_0001,
    10'b0_0100_0_0000,
    10'b1_0101_1_0101
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serIn = 1'b0;
  logic       syncEn = 1'b0;
  logic [9:0] word;
  logic       wordValid;
  logic       syncFlag;
  logic       realignReq;
  logic [3:0] realignOffset;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Monitor state
  int         cyc = 0;
  int         nWords = 0;
  int         lastValid = -1;
  int         minGap = 1000;
  int         maxGap = 0;
  int         realignCnt = 0;
  int         flagCnt = 0;
  int         overlapCnt = 0;
  logic [9:0] wordLog [16];
  logic       flagLog [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  comma_aligner u_comma_aligner (
    .clk          (clk),
    .rstN         (rstN),
    .serIn        (serIn),
    .syncEn       (syncEn),
    .word         (word),
    .wordValid    (wordValid),
    .syncFlag     (syncFlag),
    .realignReq   (realignReq),
    .realignOffset(realignOffset)
  );

  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (wordValid) begin
        if (nWords < 16) begin
          wordLog[nWords] = word;
          flagLog[nWords] = syncFlag;
        end
        if (syncFlag) flagCnt++;
        if (lastValid >= 0) begin
          if (cyc - lastValid < minGap) minGap = cyc - lastValid;
          if (cyc - lastValid > maxGap) maxGap = cyc - lastValid;
        end
        lastValid = cyc;
        nWords++;
      end
      if (realignReq) begin
        realignCnt++;
        if (wordValid) overlapCnt++;
      end
    end
  end

  task automatic chkEq(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive the bit, let the rising edge take it, return at the next falling edge.
  task automatic sendBit(logic b);
    serIn = b;
    @(negedge clk);
  endtask

  task automatic sendWord(logic [9:0] w);
    for (int i = 0; i < 10; i++) sendBit(w[i]);
  endtask

  task automatic sendZeros(int n);
    for (int i = 0; i < n; i++) sendBit(1'b0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    serIn = 1'b0;
    syncEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    cyc = 0; nWords = 0; lastValid = -1; minGap = 1000; maxGap = 0;
    realignCnt = 0; flagCnt = 0; overlapCnt = 0;
    rstN = 1'b1;
  endtask

  task automatic chkResetState();
    #1;
    chkEq("R9 word", int'(word), 0);
    chkEq("R9 wordValid", int'(wordValid), 0);
    chkEq("R9 syncFlag", int'(syncFlag), 0);
    chkEq("R9 realignReq", int'(realignReq), 0);
    chkEq("R9 realignOffset", int'(realignOffset), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    @(negedge clk);
    chkResetState();

    // Table walk: lead-in misalignment, comma, three data words, second comma, data word.
    for (int v = 0; v < NVEC; v++) begin
      logic       en;
      int         pre;
      logic       expRe;
      int         expOff;
      en     = VEC[v][9];
      pre    = int'(VEC[v][8:5]);
      expRe  = VEC[v][4];
      expOff = int'(VEC[v][3:0]);
      doReset();
      syncEn = en;
      sendZeros(pre);
      sendWord(COMMA);
      sendWord(D1);
      sendWord(D2);
      sendWord(D3);
      sendWord(COMMA);
      sendWord(D4);
      sendBit(1'b0);
      #1;
      chkEq("R4/R6 realign count", realignCnt, int'(expRe));
      chkEq("R5 offset", int'(realignOffset), expOff);
      chkEq("R4 no valid with realign", overlapCnt, 0);
      chkEq("R7 word count", nWords, 6);
      chkEq("R7 min gap", minGap, 10);
      chkEq("R7 max gap", maxGap, expRe ? 10 + pre : 10);
      if (en) begin
        chkEq("R10 word1 D1", int'(wordLog[1]), int'(D1));
        chkEq("R2 word2 D2", int'(wordLog[2]), int'(D2));
        chkEq("R10 word3 D3", int'(wordLog[3]), int'(D3));
        chkEq("R10 word4 comma", int'(wordLog[4]), int'(COMMA));
        chkEq("R10 word4 flag", int'(flagLog[4]), 1);
        chkEq("R10 word5 D4", int'(wordLog[5]), int'(D4));
        chkEq("R8 word5 flag", int'(flagLog[5]), 0);
        chkEq("R3 data flags", int'(flagLog[1]) + int'(flagLog[2]) + int'(flagLog[3]), 0);
        if (pre == 0) begin
          chkEq("R3 aligned first comma", int'(wordLog[0]), int'(COMMA));
          chkEq("R3 aligned first flag", int'(flagLog[0]), 1);
        end
      end else begin
        chkEq("R6 no flag while disabled", flagCnt, 0);
      end
    end

    // Chained realignments: shifts 3, 4, 5 give offsets 3, 7 and 2 (wrap).
    doReset();
    syncEn = 1'b1;
    sendZeros(3);
    sendWord(COMMA);
    #1;
    chkEq("R4 realign pulse", int'(realignReq), 1);
    chkEq("R4 partial dropped", int'(wordValid), 0);
    chkEq("R5 offset 3", int'(realignOffset), 3);
    sendZeros(4);
    sendWord(COMMA);
    #1;
    chkEq("R5 offset 7", int'(realignOffset), 7);
    sendZeros(5);
    sendWord(COMMA);
    #1;
    chkEq("R5 offset wraps to 2", int'(realignOffset), 2);
    chkEq("R5 realign count", realignCnt, 3);

    // Enable low: a misaligned comma changes nothing.
    syncEn = 1'b0;
    sendZeros(6);
    sendWord(COMMA);
    #1;
    chkEq("R6 no realign", int'(realignReq), 0);
    chkEq("R6 offset kept", int'(realignOffset), 2);
    chkEq("R6 realign count", realignCnt, 3);
    chkEq("R6 flag low", int'(syncFlag), 0);

    // Enable high again: boundary sits 6 bits in, so the shift is 6 and the offset becomes 8.
    syncEn = 1'b1;
    sendWord(COMMA);
    #1;
    chkEq("R4 realign after enable", int'(realignReq), 1);
    chkEq("R5 offset 8", int'(realignOffset), 8);
    sendWord(D1);
    #1;
    chkEq("R2 D1 after realign", int'(word), int'(D1));
    chkEq("R7 D1 valid", int'(wordValid), 1);
    sendWord(COMMA);
    #1;
    chkEq("R3 aligned comma valid", int'(wordValid), 1);
    chkEq("R3 aligned comma word", int'(word), int'(COMMA));
    chkEq("R3 aligned comma flag", int'(syncFlag), 1);
    chkEq("R3 no realign when aligned", int'(realignReq), 0);
    for (int i = 0; i < 5; i++) sendBit(D3[i]);
    #1;
    chkEq("R8 flag held mid-word", int'(syncFlag), 1);
    chkEq("R8 word held mid-word", int'(word), int'(COMMA));
    chkEq("R7 valid low mid-word", int'(wordValid), 0);
    for (int i = 5; i < 10; i++) sendBit(D3[i]);
    #1;
    chkEq("R2 D3 word", int'(word), int'(D3));
    chkEq("R8 flag cleared", int'(syncFlag), 0);

    // Reset in mid-stream restores the initial state.
    doReset();
    @(negedge clk);
    chkResetState();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule